// File: doc/BRIEF.md
# Limit-Checked Sticky Interrupt Status

This block watches a supply-voltage reading and a temperature reading, both 8 bits wide. It compares the voltage against a programmable window and the temperature against an over-temperature limit. It also takes per-fan fault flags, gated by each fan's drive-enable, and per-sensor fault flags. It latches every out-of-range event into an 8-bit sticky status register. While any unmasked status bit is set, a single alert output is held high.

Software reaches the block through a small register bus. The bus has one-cycle read and write strobes, a 3-bit address and registered read data. Reading the status register clears only those bits whose cause has gone away. The over-temperature bit needs the reading to drop further, below its limit minus a programmable hysteresis, before it can be cleared. A lock input protects the mask and hysteresis registers. The limit registers stay writable while the lock is set.

Top module: `limit_irq_status`

## Requirements
- R1: After reset, reads return: status (address 0) 0x00, mask (address 1) 0x00, voltage low limit (address 2) 0x00, voltage high limit (address 3) 0xFF, over-temperature limit (address 4) 0xFF, hysteresis (address 5) 0x00. Unmapped addresses 6 and 7 read 0x00. alert_o is low.
- R2: Status bit 0 is set in the cycle after the voltage reading is strictly greater than the high limit. A reading equal to the high limit does not set it.
- R3: Status bit 0 is set in the cycle after the voltage reading is less than or equal to the low limit.
- R4: A status bit stays set after its condition goes away, until a status read clears it.
- R5: A read of address 0 returns the status value as it was in the read cycle (rdata_o is valid one cycle after the strobe). The read clears only the bits whose condition is absent in that cycle. A condition present in a cycle sets its bit again in the next cycle.
- R6: Status bit 1 is set after the temperature is strictly greater than the over-temperature limit. A status read clears it only when temperature + hysteresis < limit.
- R7: Status bits 2 to 5 flag fans 0 to 3. A fan's bit is set only when both fan_fault_i and pwm_on_i are high for that fan.
- R8: Status bits 6 and 7 latch sns_fault_i[0] and sns_fault_i[1].
- R9: alert_o is high exactly when some status bit is set whose mask bit is 0. A mask bit of 1 hides that status bit from alert_o but leaves it latched.
- R10: While lock_i is high, writes to the mask (address 1) and hysteresis (address 5) registers are ignored. Writes to the limit registers (addresses 2, 3 and 4) still take effect.
- R11: Reads of other addresses and writes to any address, including address 0, leave the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_i | input | 1 | Write protect for mask and hysteresis |
| volt_i | input | 8 | Voltage reading |
| temp_i | input | 8 | Temperature reading |
| fan_fault_i | input | 4 | Per-fan slow or stalled indication |
| pwm_on_i | input | 4 | Per-fan drive enable |
| sns_fault_i | input | 2 | Per-sensor open or short indication |
| rd_en_i | input | 1 | One-cycle read strobe |
| wr_en_i | input | 1 | One-cycle write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| alert_o | output | 1 | Combined unmasked interrupt |

## Verification
A status bit in the wrong state shows up on alert_o one clock after the cause, as long as that bit is unmasked. It shows up on the next status read in any case. A clear that happens too early, for example one that ignores the hysteresis or a cause that is still present, shows up as a zero on the second of two back-to-back reads. A wrong limit or mask value stays hidden until a reading crosses that limit or the bit is read back. The random phase therefore mixes register writes and reads with readings spread over the whole 8-bit range.

// File: rtl/limit_irq_status.sv
`timescale 1ns/1ps
module limit_irq_status #(
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int NFAN = 4,
  parameter int NSNS = 2
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            lock_i,
  input  logic [DW-1:0]   volt_i,
  input  logic [DW-1:0]   temp_i,
  input  logic [NFAN-1:0] fan_fault_i,
  input  logic [NFAN-1:0] pwm_on_i,
  input  logic [NSNS-1:0] sns_fault_i,
  input  logic            rd_en_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            alert_o
);
  localparam int SW = 2 + NFAN + NSNS;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_VLO  = AW'(2);
  localparam logic [AW-1:0] A_VHI  = AW'(3);
  localparam logic [AW-1:0] A_OTL  = AW'(4);
  localparam logic [AW-1:0] A_HYS  = AW'(5);

  logic [SW-1:0] stat_q, mask_q, cond, keep;
  logic [DW-1:0] vlo_q, vhi_q, otl_q, hys_q, rd_mux;
  logic          clr, volt_bad, ot_bad, ot_hold;

  assign volt_bad = (volt_i > vhi_q) || (volt_i <= vlo_q);
  assign ot_bad   = temp_i > otl_q;
  assign ot_hold  = ((DW+1)'(temp_i) + (DW+1)'(hys_q)) >= (DW+1)'(otl_q);
  assign cond     = {sns_fault_i, fan_fault_i & pwm_on_i, ot_bad,  volt_bad};
  assign keep     = {sns_fault_i, fan_fault_i & pwm_on_i, ot_hold, volt_bad};
  assign clr      = rd_en_i && (addr_i == A_STAT);
  assign alert_o  = |(stat_q & ~mask_q);

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (clr ? (stat_q & keep) : stat_q) | cond;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      vlo_q  <= '0;
      vhi_q  <= '1;
      otl_q  <= '1;
      hys_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_MASK: if (!lock_i) mask_q <= SW'(wdata_i);
        A_VLO:  vlo_q <= wdata_i;
        A_VHI:  vhi_q <= wdata_i;
        A_OTL:  otl_q <= wdata_i;
        A_HYS:  if (!lock_i) hys_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_STAT:  rd_mux = DW'(stat_q);
      A_MASK:  rd_mux = DW'(mask_q);
      A_VLO:   rd_mux = vlo_q;
      A_VHI:   rd_mux = vhi_q;
      A_OTL:   rd_mux = otl_q;
      A_HYS:   rd_mux = hys_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

module limit_irq_status_chk #(
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int NFAN = 4,
  parameter int SW   = 8
)(
  input logic            clk,
  input logic            rst,
  input logic [SW-1:0]   stat,
  input logic [SW-1:0]   mask,
  input logic [DW-1:0]   volt,
  input logic [DW-1:0]   temp,
  input logic [DW-1:0]   vlo,
  input logic [DW-1:0]   vhi,
  input logic [DW-1:0]   otl,
  input logic [DW-1:0]   hys,
  input logic            clr,
  input logic            lock,
  input logic            wr,
  input logic [AW-1:0]   addr,
  input logic [NFAN-1:0] fan_fault,
  input logic [NFAN-1:0] pwm_on,
  input logic            alert
);
  a_r2_high_sets: assert property (@(posedge clk) disable iff (rst)
    (volt > vhi) |=> stat[0]);
  a_r3_low_sets: assert property (@(posedge clk) disable iff (rst)
    (volt <= vlo) |=> stat[0]);
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat[0] && !clr) |=> stat[0]);
  a_r6_hyst_hold: assert property (@(posedge clk) disable iff (rst)
    (stat[1] && (((DW+1)'(temp) + (DW+1)'(hys)) >= (DW+1)'(otl))) |=> stat[1]);
  a_r7_fan_gated: assert property (@(posedge clk) disable iff (rst)
    (stat[2 +: NFAN] & ~$past(stat[2 +: NFAN]) & ~$past(fan_fault & pwm_on)) == '0);
  a_r9_alert_quiet: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~mask) == '0) |-> !alert);
  a_r10_mask_locked: assert property (@(posedge clk) disable iff (rst)
    (wr && lock && addr == AW'(1)) |=> $stable(mask));
endmodule

bind limit_irq_status limit_irq_status_chk #(.DW(DW), .AW(AW), .NFAN(NFAN), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .stat(stat_q), .mask(mask_q), .volt(volt_i), .temp(temp_i),
  .vlo(vlo_q), .vhi(vhi_q), .otl(otl_q), .hys(hys_q), .clr(clr), .lock(lock_i),
  .wr(wr_en_i), .addr(addr_i), .fan_fault(fan_fault_i), .pwm_on(pwm_on_i), .alert(alert_o));

// File: tb/test_limit_irq_status.sv
`timescale 1ns/1ps
module test_limit_irq_status;
  logic       clk = 0, rst = 1, lock_i = 0, rd_en_i = 0, wr_en_i = 0;
  logic [7:0] volt_i = 8'h80, temp_i = 8'h40, wdata_i = 0;
  logic [3:0] fan_fault_i = 0, pwm_on_i = 0;
  logic [1:0] sns_fault_i = 0;
  logic [2:0] addr_i = 0;
  logic [7:0] rdata_o;
  logic       alert_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_stat, m_mask, m_lo, m_hi, m_ot, m_hy;

  limit_irq_status i_limit_irq_status (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_stat;
      3'd1: return m_mask;
      3'd2: return m_lo;
      3'd3: return m_hi;
      3'd4: return m_ot;
      3'd5: return m_hy;
      default: return 8'h00;
    endcase
  endfunction

  task automatic step();
    logic [7:0] c, k, rexp;
    logic rdq;
    @(posedge clk);
    c = {sns_fault_i, fan_fault_i & pwm_on_i, temp_i > m_ot, (volt_i > m_hi) || (volt_i <= m_lo)};
    k = c;
    k[1] = ({1'b0, temp_i} + {1'b0, m_hy}) >= {1'b0, m_ot};
    rdq = rd_en_i;
    rexp = model_rd(addr_i);
    m_stat = ((rd_en_i && addr_i == 3'd0) ? (m_stat & k) : m_stat) | c;
    if (wr_en_i) begin
      case (addr_i)
        3'd1: if (!lock_i) m_mask = wdata_i;
        3'd2: m_lo = wdata_i;
        3'd3: m_hi = wdata_i;
        3'd4: m_ot = wdata_i;
        3'd5: if (!lock_i) m_hy = wdata_i;
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R9 alert", {7'd0, alert_o}, {7'd0, |(m_stat & ~m_mask)});
    if (rdq) chk("R5 read", rdata_o, rexp);
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
    rd_en_i = 1; addr_i = a;
    step();
    d = rdata_o;
    rd_en_i = 0;
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] v);
    wr_en_i = 1; addr_i = a; wdata_i = v;
    step();
    wr_en_i = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    do_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_stat = 0; m_mask = 0; m_lo = 0; m_hi = 8'hFF; m_ot = 8'hFF; m_hy = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 alert", {7'd0, alert_o}, 8'h00);
    rd_chk("R1 status", 3'd0, 8'h00);
    rd_chk("R1 mask",   3'd1, 8'h00);
    rd_chk("R1 vlo",    3'd2, 8'h00);
    rd_chk("R1 vhi",    3'd3, 8'hFF);
    rd_chk("R1 otl",    3'd4, 8'hFF);
    rd_chk("R1 hyst",   3'd5, 8'h00);
    rd_chk("R1 unmapped", 3'd6, 8'h00);
    rd_chk("R1 unmapped", 3'd7, 8'h00);

    // R2 strict greater
    do_wr(3'd3, 8'h90);
    volt_i = 8'h90; step();
    rd_chk("R2 equal no flag", 3'd0, 8'h00);
    volt_i = 8'h91; step();
    rd_chk("R2 above flags", 3'd0, 8'h01);
    volt_i = 8'h80; step();
    rd_chk("R4 sticky", 3'd0, 8'h01);
    rd_chk("R5 cleared", 3'd0, 8'h00);

    // R3 less or equal
    do_wr(3'd2, 8'h20);
    volt_i = 8'h21; step();
    rd_chk("R3 above low", 3'd0, 8'h00);
    volt_i = 8'h20; step(); volt_i = 8'h80;
    rd_chk("R3 equal low", 3'd0, 8'h01);
    rd_chk("R3 cleared", 3'd0, 8'h00);

    // R5 persisting condition
    volt_i = 8'h95; step();
    rd_chk("R5 active", 3'd0, 8'h01);
    rd_chk("R5 not cleared", 3'd0, 8'h01);
    volt_i = 8'h80;
    rd_chk("R5 last", 3'd0, 8'h01);
    rd_chk("R5 gone", 3'd0, 8'h00);

    // R6 hysteresis
    do_wr(3'd4, 8'h60);
    do_wr(3'd5, 8'h05);
    temp_i = 8'h60; step();
    rd_chk("R6 equal no flag", 3'd0, 8'h00);
    temp_i = 8'h61; step();
    temp_i = 8'h5C;
    rd_chk("R6 set", 3'd0, 8'h02);
    rd_chk("R6 held by hyst", 3'd0, 8'h02);
    temp_i = 8'h5A;
    rd_chk("R6 below band", 3'd0, 8'h02);
    rd_chk("R6 cleared", 3'd0, 8'h00);
    temp_i = 8'h40;

    // R7 fan gating
    fan_fault_i = 4'hF; pwm_on_i = 4'h0; step();
    rd_chk("R7 pwm off", 3'd0, 8'h00);
    pwm_on_i = 4'b0101; step();
    fan_fault_i = 0; pwm_on_i = 0;
    rd_chk("R7 gated fans", 3'd0, 8'h14);
    rd_chk("R7 cleared", 3'd0, 8'h00);

    // R8 sensor faults
    sns_fault_i = 2'b10; step(); sns_fault_i = 0;
    rd_chk("R8 sensor1", 3'd0, 8'h80);
    rd_chk("R8 cleared", 3'd0, 8'h00);

    // R9 mask
    sns_fault_i = 2'b01; step(); sns_fault_i = 0;
    chk("R9 alert set", {7'd0, alert_o}, 8'h01);
    do_wr(3'd1, 8'h40);
    chk("R9 masked", {7'd0, alert_o}, 8'h00);
    rd_chk("R9 still latched", 3'd0, 8'h40);
    do_wr(3'd1, 8'h00);

    // R10 lock
    lock_i = 1;
    do_wr(3'd1, 8'hFF);
    do_wr(3'd5, 8'h33);
    do_wr(3'd2, 8'h10);
    rd_chk("R10 mask locked", 3'd1, 8'h00);
    rd_chk("R10 hyst locked", 3'd5, 8'h05);
    rd_chk("R10 limit writable", 3'd2, 8'h10);
    lock_i = 0;

    // R11 other accesses do not clear
    volt_i = 8'h95; step(); volt_i = 8'h80;
    rd_chk("R11 other read", 3'd2, 8'h10);
    do_wr(3'd0, 8'h00);
    rd_chk("R11 status kept", 3'd0, 8'h01);
    rd_chk("R11 then cleared", 3'd0, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      int op;
      volt_i = 8'($urandom);
      temp_i = 8'($urandom);
      fan_fault_i = 4'($urandom);
      pwm_on_i = 4'($urandom);
      sns_fault_i = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      lock_i = ($urandom % 4 == 0);
      op = int'($urandom % 10);
      rd_en_i = 0; wr_en_i = 0;
      addr_i = 3'($urandom);
      wdata_i = 8'($urandom);
      if (op < 4) rd_en_i = 1;
      else if (op == 4) wr_en_i = 1;
      step();
    end
    rd_en_i = 0; wr_en_i = 0;
    finish_run();
  end
endmodule